// File: doc/BRIEF.md
# Serially Concatenated Convolutional Encoder

This block turns a serial stream of information bits into coded blocks for an iterative (turbo-style) receiver. Each bit first passes through a 16-state recursive systematic encoder of rate 1/2. A rate-dependent puncturer then thins out the parity bits. The surviving bits are stored in a row/column block interleaver. On the way out of the interleaver, a two-state differential encoder of rate 1 recodes each bit. Only the puncturing pattern changes with the code rate. The number of information bits per block is chosen per rate, so that every block fills the interleaver exactly.

Bits enter one per cycle under a valid/ready handshake. The rate code is sampled together with the first bit of each block and applies to the whole block. After the last information bit, the block accepts no input for four cycles while it appends termination bits that return the outer encoder to the all-zero state. The interleaver has two banks that alternate, so the next block can be written while the previous one is read out. The output is a plain stream with a valid flag and an end-of-block flag, one coded bit per cycle. The interleaver is `ROWS` × `COLS`. The deployed setting is 100 × 120 (12000 bits), and the default parameters are a reduced array for fast elaboration.

Top module: `scc_encoder`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For rate code `in_rate` with parity period N, a block holds ROWS·COLS·N/(N+1) − 4 information bits. Rate codes and periods are: 0 → rate 1/2, N=1; 1 → 2/3, N=2; 2 → 3/4, N=3; 3 → 5/6, N=5; 4 → 7/8, N=7. After the last information bit is accepted, `in_ready` is low for exactly the next 4 cycles.
- R3: The outer encoder computes a = u ⊕ a(k−3) ⊕ a(k−4) and parity p = a ⊕ a(k−1) ⊕ a(k−2) ⊕ a(k−4), with the systematic bit equal to u. Its 4 termination inputs equal a(k−3) ⊕ a(k−4), which leaves the register all zero at block end.
- R4: Steps are numbered from 0 within the block, tail included. Every systematic bit is kept. The parity bit is kept only on steps whose index mod N is 0. The systematic bit is placed before the parity bit of the same step.
- R5: The kept bits are written row by row into a ROWS × COLS array, at linear address row·COLS+col. They are read column by column: the row index advances first, then the column.
- R6: Each output bit is c = x ⊕ c_prev, where x is the interleaver bit. c_prev is taken as 0 for the first bit of every block.
- R7: Each block yields exactly ROWS·COLS output bits on consecutive cycles. `out_last` is 1 on the final bit only.
- R8: `in_rate` is used only with a block's first bit. Values presented with later bits of that block have no effect.
- R9: Two blocks may be held at once. A new block is accepted while the previous one is being output. While both banks hold unread blocks, `in_ready` stays low.
- R10: A block of all-zero information bits produces all-zero output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Bit accepted when high together with `in_valid` |
| in_bit | input | 1 | Information bit |
| in_rate | input | 3 | Rate code (0..4), sampled with a block's first bit |
| out_valid | output | 1 | Coded bit present |
| out_bit | output | 1 | Coded bit after the differential encoder |
| out_last | output | 1 | Marks the final coded bit of a block |

## Verification
The assertions check the following properties every cycle:
- the input stays closed during the termination tail;
- the outer register is zero after each tail;
- the rate is held within a block;
- no write lands in a bank that is still unread;
- every block ends exactly at the interleaver length;
- a read-out, once started, continues without gaps;
- the differential state restarts on each block's first bit.

Some behaviours only the bench's block scenarios can show:
- the bit-exact coded stream under each puncturing rate;
- the column-wise read order;
- the all-zero mapping;
- the overlap and stall of the two banks;
- recovery from a reset that arrives in the middle of a block.

// File: rtl/scc_pkg.sv
package scc_pkg;

    // Termination steps appended to each block by the outer encoder.
    localparam int TAIL_LEN = 4;

    // Parity keep period for a rate code; unknown codes fall back to rate 1/2.
    function automatic int par_period(input logic [2:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 7;
            default: return 1;
        endcase
    endfunction

    // Information bits that make a block of blk_len kept bits at this rate.
    function automatic int info_len(input logic [2:0] code, input int blk_len);
        int n;
        n = par_period(code);
        return (blk_len * n) / (n + 1) - TAIL_LEN;
    endfunction

endpackage

// File: rtl/scc_outer_rsc.sv
module scc_outer_rsc #(
    parameter int MEM = 4,
    parameter logic [MEM-1:0] FB_TAPS  = 4'b1100,  // bit i is D^(i+1): D^3, D^4
    parameter logic [MEM-1:0] PAR_TAPS = 4'b1011   // D^1, D^2, D^4 (D^0 implicit)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic term_i,
    input  logic data_i,
    output logic sys_o,
    output logic par_o,
    output logic zero_o
);

    typedef struct packed {
        logic [MEM-1:0] sr;
    } rsc_t;

    rsc_t q, d;
    logic fb;
    logic a;

    always_comb begin
        d      = q;
        fb     = ^(q.sr & FB_TAPS);
        sys_o  = term_i ? fb : data_i;
        a      = sys_o ^ fb;
        par_o  = a ^ (^(q.sr & PAR_TAPS));
        zero_o = (q.sr == '0);
        if (step_i) begin
            d.sr = {q.sr[MEM-2:0], a};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/scc_ilv.sv
module scc_ilv #(
    parameter int ROWS = 6,
    parameter int COLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_two_i,
    input  logic wr_b0_i,
    input  logic wr_b1_i,
    input  logic wr_done_i,
    output logic wr_ok_o,
    output logic rd_valid_o,
    output logic rd_bit_o,
    output logic rd_first_o,
    output logic rd_last_o
);

    localparam int LEN = ROWS * COLS;
    localparam int AW  = $clog2(LEN);
    localparam int RW  = $clog2(ROWS);
    localparam int CW  = $clog2(COLS);

    typedef struct packed {
        logic          wsel;
        logic          rsel;
        logic [1:0]    full;
        logic [AW-1:0] wptr;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } ilv_t;

    ilv_t q, d;
    logic [LEN-1:0] mem_q [2];
    logic [AW-1:0]  wptr1;
    logic [AW-1:0]  rd_addr;

    always_comb begin
        d       = q;
        wptr1   = q.wptr + 1'b1;
        rd_addr = AW'(q.row) * AW'(COLS) + AW'(q.col);

        wr_ok_o    = !q.full[q.wsel];
        rd_valid_o = q.full[q.rsel];
        rd_bit_o   = mem_q[q.rsel][rd_addr];
        rd_first_o = (q.row == '0) && (q.col == '0);
        rd_last_o  = (q.row == RW'(ROWS - 1)) && (q.col == CW'(COLS - 1));

        // write side: row-major fill of the current write bank
        if (wr_en_i) begin
            if (wr_done_i) begin
                d.full[q.wsel] = 1'b1;
                d.wsel         = ~q.wsel;
                d.wptr         = '0;
            end else begin
                d.wptr = q.wptr + (wr_two_i ? AW'(2) : AW'(1));
            end
        end

        // read side: column-major drain, row index fastest
        if (rd_valid_o) begin
            if (q.row == RW'(ROWS - 1)) begin
                d.row = '0;
                if (q.col == CW'(COLS - 1)) begin
                    d.col          = '0;
                    d.full[q.rsel] = 1'b0;
                    d.rsel         = ~q.rsel;
                end else begin
                    d.col = q.col + 1'b1;
                end
            end else begin
                d.row = q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[q.wsel][q.wptr] <= wr_b0_i;
            if (wr_two_i) begin
                mem_q[q.wsel][wptr1] <= wr_b1_i;
            end
        end
    end

    // R9: the writer never lands in a bank still awaiting read-out
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !q.full[q.wsel]);

    // R5: a block closes exactly when the array is full
    a_r5_exact_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_done_i) |-> (int'(q.wptr) + (wr_two_i ? 2 : 1) == LEN));

    // R7: read-out, once begun, runs on consecutive cycles to the end
    a_r7_steady_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_last_o) |=> rd_valid_o);

endmodule

// File: rtl/scc_diff_inner.sv
module scc_diff_inner (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    input  logic in_bit_i,
    input  logic in_first_i,
    input  logic in_last_i,
    output logic out_valid_o,
    output logic out_bit_o,
    output logic out_last_o
);

    typedef struct packed {
        logic vld;
        logic val;
        logic lst;
    } dif_t;

    dif_t q, d;

    always_comb begin
        d     = q;
        d.vld = in_valid_i;
        d.lst = 1'b0;
        if (in_valid_i) begin
            d.val = in_bit_i ^ (in_first_i ? 1'b0 : q.val);
            d.lst = in_last_i;
        end
        out_valid_o = q.vld;
        out_bit_o   = q.val;
        out_last_o  = q.lst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: the first bit of a block passes with a cleared accumulator
    a_r6_fresh_state: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_first_i) |=> (out_bit_o == $past(in_bit_i)));

    // R7: end-of-block flag only accompanies a valid bit
    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

endmodule

// File: rtl/scc_encoder.sv
module scc_encoder #(
    parameter int ROWS = 6,
    parameter int COLS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic [2:0] in_rate,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);

    import scc_pkg::*;

    localparam int LEN = ROWS * COLS;
    localparam int NW  = $clog2(LEN) + 1;
    localparam int TW  = $clog2(TAIL_LEN);

    typedef enum logic {W_DATA, W_TAIL} wst_e;

    typedef struct packed {
        wst_e          st;
        logic [2:0]    rate;
        logic [NW-1:0] cnt;
        logic [2:0]    phase;
        logic [TW-1:0] tcnt;
    } enc_t;

    enc_t q, d;

    logic [2:0] rate_eff;
    int         period;
    int         ilen;
    logic       fire;
    logic       step;
    logic       keep_par;
    logic       tail_end;
    logic       ilv_ok;
    logic       sys_b;
    logic       par_b;
    logic       rsc_zero;
    logic       rd_valid;
    logic       rd_bit;
    logic       rd_first;
    logic       rd_last;

    always_comb begin
        d        = q;
        rate_eff = (q.st == W_DATA && q.cnt == '0) ? in_rate : q.rate;
        period   = par_period(rate_eff);
        ilen     = info_len(rate_eff, LEN);
        in_ready = (q.st == W_DATA) && ilv_ok;
        fire     = in_valid && in_ready;
        step     = fire || (q.st == W_TAIL);
        keep_par = (q.phase == '0);
        tail_end = (q.st == W_TAIL) && (q.tcnt == TW'(TAIL_LEN - 1));

        if (step) begin
            d.phase = (int'(q.phase) == period - 1) ? 3'd0 : q.phase + 3'd1;
        end

        if (fire) begin
            d.rate = rate_eff;
            d.cnt  = q.cnt + 1'b1;
            if (int'(q.cnt) == ilen - 1) begin
                d.st   = W_TAIL;
                d.tcnt = '0;
            end
        end

        if (q.st == W_TAIL) begin
            d.tcnt = q.tcnt + 1'b1;
            if (tail_end) begin
                d.st    = W_DATA;
                d.cnt   = '0;
                d.phase = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: W_DATA, rate: 3'd0, cnt: '0, phase: 3'd0, tcnt: '0};
        end else begin
            q <= d;
        end
    end

    scc_outer_rsc u_outer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .term_i (q.st == W_TAIL),
        .data_i (in_bit),
        .sys_o  (sys_b),
        .par_o  (par_b),
        .zero_o (rsc_zero)
    );

    scc_ilv #(.ROWS(ROWS), .COLS(COLS)) u_ilv (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (step),
        .wr_two_i   (keep_par),
        .wr_b0_i    (sys_b),
        .wr_b1_i    (par_b),
        .wr_done_i  (tail_end),
        .wr_ok_o    (ilv_ok),
        .rd_valid_o (rd_valid),
        .rd_bit_o   (rd_bit),
        .rd_first_o (rd_first),
        .rd_last_o  (rd_last)
    );

    scc_diff_inner u_inner (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (rd_valid),
        .in_bit_i    (rd_bit),
        .in_first_i  (rd_first),
        .in_last_i   (rd_last),
        .out_valid_o (out_valid),
        .out_bit_o   (out_bit),
        .out_last_o  (out_last)
    );

    // R2: no information bit is taken while termination runs
    a_r2_tail_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == W_TAIL) |-> !in_ready);

    // R3: termination leaves the outer register cleared
    a_r3_terminated: assert property (@(posedge clk) disable iff (!rst_n)
        tail_end |=> rsc_zero);

    // R8: the captured rate does not move after the first bit of a block
    a_r8_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && q.cnt != '0) |=> $stable(q.rate));

endmodule

// File: tb/scc_encoder_tb_top.sv
module scc_encoder_tb_top;

    localparam int ROWS = 6;
    localparam int COLS = 8;
    localparam int LEN  = ROWS * COLS;
    localparam int NB   = 7;
    localparam int MAXB = (NB + 2) * LEN;
    localparam int TB_RATE [NB] = '{0, 1, 2, 3, 4, 2, 0};
    localparam int TB_SEED [NB] = '{0, 11, 23, 37, 5, 19, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_bit = 1'b0;
    logic [2:0] in_rate = 3'd0;
    logic       out_valid;
    logic       out_bit;
    logic       out_last;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_q [MAXB];
    bit  exp_zero [NB + 2];
    int  ewr = 0;
    int  eblk = 0;
    int  oidx = 0;
    int  oblk = 0;
    int  pos = 0;
    int  blk_bad = 0;
    int  last_bad = 0;
    int  ones = 0;
    int  gaps = 0;
    bit  overlap_seen = 0;
    bit  stall_seen = 0;

    always #5 clk = ~clk;

    scc_encoder #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .in_rate   (in_rate),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tb_period(input int r);
        case (r)
            1: return 2;
            2: return 3;
            3: return 5;
            4: return 7;
            default: return 1;
        endcase
    endfunction

    function automatic int tb_info(input int r);
        int n;
        n = tb_period(r);
        return LEN * n / (n + 1) - 4;
    endfunction

    function automatic bit pat(input int seed, input int i);
        int v;
        v = i * seed + (i >> 3) * 13 + seed;
        if (seed == 0) return 1'b0;
        return v[0] ^ v[2] ^ v[5];
    endfunction

    // Reference model built from R3..R6
    task automatic build_expected(input int r, input int seed);
        bit arr [LEN];
        bit s1, s2, s3, s4, u, a, p, c;
        int n, il, w;
        n = tb_period(r);
        il = tb_info(r);
        s1 = 0; s2 = 0; s3 = 0; s4 = 0; w = 0;
        for (int i = 0; i < il + 4; i++) begin
            u = (i < il) ? pat(seed, i) : (s3 ^ s4);
            a = u ^ s3 ^ s4;
            p = a ^ s1 ^ s2 ^ s4;
            s4 = s3; s3 = s2; s2 = s1; s1 = a;
            arr[w] = u; w++;
            if (i % n == 0) begin arr[w] = p; w++; end
        end
        c = 0;
        for (int col = 0; col < COLS; col++) begin
            for (int row = 0; row < ROWS; row++) begin
                c = (col == 0 && row == 0) ? arr[0] : (arr[row * COLS + col] ^ c);
                exp_q[ewr] = c;
                ewr++;
            end
        end
        exp_zero[eblk] = (seed == 0);
        eblk++;
    endtask

    // Drives one full block; starts and ends at a falling edge
    task automatic send_block(input int r, input int seed);
        int il, waited, low_cnt;
        il = tb_info(r);
        build_expected(r, seed);
        for (int i = 0; i < il; i++) begin
            in_valid = 1'b1;
            in_bit   = pat(seed, i);
            in_rate  = (i == 0) ? 3'(r) : 3'((r + 1) % 5);  // R8 decoy
            waited = 0;
            #1;
            while (!in_ready) begin
                waited++;
                @(negedge clk);
                #1;
            end
            if (i == 0 && waited > 0 && out_valid) stall_seen = 1;
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        low_cnt = 0;
        for (int k = 0; k < 4; k++) begin
            #1;
            if (!in_ready) low_cnt++;
            @(negedge clk);
        end
        check(low_cnt == 4, "R2 input closed for tail", low_cnt, 4);
    endtask

    // Output monitor: compares against the model, checks framing per block
    always @(negedge clk) begin
        if (!rst_n) begin
            pos = 0; blk_bad = 0; last_bad = 0; ones = 0;
        end else begin
            if (out_valid) begin
                if (out_bit !== exp_q[oidx]) blk_bad++;
                if (out_last !== (pos == LEN - 1)) last_bad++;
                if (out_bit) ones++;
                pos++;
                oidx++;
                if (pos == LEN) begin
                    check(blk_bad == 0, "R3 R4 R5 R6 R8 coded stream mismatches", blk_bad, 0);
                    check(last_bad == 0, "R7 last flag placement errors", last_bad, 0);
                    if (exp_zero[oblk]) check(ones == 0, "R10 zero block ones", ones, 0);
                    oblk++;
                    pos = 0; blk_bad = 0; last_bad = 0; ones = 0;
                end
            end else if (pos != 0) begin
                gaps++;
            end
            if (out_valid && in_ready) overlap_seen = 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", oidx, ewr);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        @(negedge clk);

        // table walk: one block per entry, back to back
        for (int b = 0; b < NB; b++) begin
            send_block(TB_RATE[b], TB_SEED[b]);
        end
        while (oidx < ewr) @(negedge clk);
        check(oblk == NB, "R7 blocks emitted", oblk, NB);
        check(gaps == 0, "R7 gaps inside blocks", gaps, 0);
        check(overlap_seen, "R9 input accepted during output", overlap_seen, 1);
        check(stall_seen, "R9 stall with both banks full", stall_seen, 1);

        // directed: reset in the middle of a block
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1;
            in_bit   = 1'b1;
            in_rate  = 3'd3;
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 out_valid mid-block reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready mid-block reset", in_ready, 1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        send_block(4, 29);
        while (oidx < ewr) @(negedge clk);
        check(oblk == NB + 1, "R3 R6 clean block after reset", oblk, NB + 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule